// File: doc/BRIEF.md
# Power Mode Controller

This block sequences a small system through four operating modes, from fully clocked to fully stopped. Software requests a mode with a single-cycle write that carries a 2-bit mode code. The controller then drives a CPU clock enable, one clock enable per peripheral and a system clock enable. While a low-power mode is active it watches the wake sources that apply to that mode and returns the system to full operation when one of them fires.

The two deeper modes are not entered at once. The controller first asks each affected peripheral to stop and waits for the acknowledges, or for a bounded timeout. It then gates the peripheral clocks, then the CPU clock, and for the deepest mode the system clock last. The controller runs on an always-on clock. The wake pin is caught by an asynchronously set flop, so a pulse shorter than a clock period is not lost. The NMI line passes through a two-flop synchronizer before its falling edge is detected.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode status reads 0 (Run), `cpu_clk_en` and `sys_clk_en` are 1, `periph_clk_en` equals `periph_run_en` and `periph_stop_req` is 0. Status and request codes are Run=0, Idle=1, Sleep=2, Deep Sleep=3.
- R2: In Run, `periph_clk_en` follows `periph_run_en` bit for bit, and both the CPU and system clock enables are 1.
- R3: A request with code 1 made in Run gives, one cycle later, status 1, `cpu_clk_en`=0, `sys_clk_en`=1 and `periph_clk_en` equal to `periph_run_en`.
- R4: Idle returns to Run on the clock edge after a watchdog event or after any `periph_irq` bit is set. A falling edge on `nmi_n` returns Idle to Run on the third clock edge after the fall. The wake pin has no effect in Idle.
- R5: In Sleep the status is 2, `cpu_clk_en` is 0, `sys_clk_en` is 1 and `periph_clk_en` equals `periph_run_en & periph_sleep_en`.
- R6: Sleep returns to Run on a watchdog event, on a falling edge of `nmi_n`, or on an interrupt at bit i where `periph_run_en[i]` and `periph_sleep_en[i]` are both set. Interrupts from gated peripherals are ignored.
- R7: In Deep Sleep the status is 3 and all clock enables are 0. Only `ext_wake` returns the system to Run, by the third clock edge after it rises, even for a pulse shorter than a clock period. Watchdog, NMI and interrupts are ignored.
- R8: Sleep or Deep Sleep entry raises `periph_stop_req` on the affected set (`run_en & ~sleep_en` for Sleep, `run_en` for Deep Sleep) in the first cycle after the request. One cycle after all affected acknowledges are seen, the affected peripheral clocks are gated. The CPU clock is gated in the next cycle, and the target mode is reached in the cycle after that. Stop requests stay high until the return to Run.
- R9: If acknowledges are missing, peripheral gating occurs on the 17th clock edge after the request, after 16 cycles of waiting.
- R10: A mode request made while the shutdown sequence runs is ignored.
- R11: A watchdog event or an NMI fall during a shutdown toward Sleep is remembered. Sleep is reached, and the next cycle returns to Run.
- R12: Asserting `rst_n` forces the Run outputs at once from any mode, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req_valid | input | 1 | One-cycle software mode write strobe |
| mode_req_code | input | 2 | Requested mode code |
| periph_run_en | input | N_PERIPH | Software peripheral clock enables |
| periph_sleep_en | input | N_PERIPH | Peripherals kept clocked in Sleep |
| periph_irq | input | N_PERIPH | Enabled interrupt requests per peripheral |
| wdt_event | input | 1 | Watchdog event pulse |
| nmi_n | input | 1 | Asynchronous NMI, active on falling edge |
| ext_wake | input | 1 | Asynchronous external wake pin |
| periph_stop_ack | input | N_PERIPH | Peripheral stop acknowledges |
| periph_stop_req | output | N_PERIPH | Stop requests to peripherals |
| periph_clk_en | output | N_PERIPH | Peripheral clock enables |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | System clock enable |
| mode_status | output | 2 | Current mode code |

## Verification
The risky overlap is a wake event that lands in the same cycle as, or inside, a shutdown sequence. A watchdog pulse during the acknowledge wait could be dropped, and a software write during the wait could redirect the sequence. The bench forces a long wait by withholding one acknowledge. It pulses the watchdog and a competing Idle request inside that window. It then expects, at fixed cycle counts, that gating still happens on the 17th edge, that Sleep is reached, and that Run follows one cycle later.

// File: rtl/pwr_mode_pkg.sv
`timescale 1ns/1ps
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_SLEEP = 2'd2,
    MODE_DEEP  = 2'd3
  } pwr_mode_e;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_IDLE     = 3'd1,
    ST_SLEEP    = 3'd2,
    ST_DEEP     = 3'd3,
    ST_STOP_REQ = 3'd4,
    ST_GATE_PER = 3'd5,
    ST_GATE_CPU = 3'd6
  } pwr_state_e;

  function automatic logic in_shutdown(pwr_state_e s);
    return (s == ST_STOP_REQ) || (s == ST_GATE_PER) || (s == ST_GATE_CPU);
  endfunction

endpackage

// File: rtl/pwr_rst_sync.sv
`timescale 1ns/1ps
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) pipe_q <= '0;
    else              pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/pwr_wake_detect.sv
`timescale 1ns/1ps
module pwr_wake_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic ext_wake,
  input  logic deep_active,
  output logic nmi_fall,
  output logic ext_wake_seen
);
  // NMI synchronizer plus one history flop for the edge detector
  logic [SYNC_STAGES:0]   nmi_pipe_q;
  logic                   wake_hold_q;
  logic [SYNC_STAGES-1:0] wake_pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_pipe_q <= '1;
    else        nmi_pipe_q <= {nmi_pipe_q[SYNC_STAGES-1:0], nmi_n};
  end

  assign nmi_fall = nmi_pipe_q[SYNC_STAGES] & ~nmi_pipe_q[SYNC_STAGES-1];

  // Wake pin capture: set without a clock edge, cleared outside Deep Sleep
  always_ff @(posedge clk or negedge rst_n or posedge ext_wake) begin
    if (!rst_n)            wake_hold_q <= 1'b0;
    else if (ext_wake)     wake_hold_q <= 1'b1;
    else if (!deep_active) wake_hold_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wake_pipe_q <= '0;
    else if (!deep_active) wake_pipe_q <= '0;
    else                   wake_pipe_q <= {wake_pipe_q[SYNC_STAGES-2:0], wake_hold_q};
  end

  assign ext_wake_seen = wake_pipe_q[SYNC_STAGES-1];

  // R4
  nmi_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_fall |=> !nmi_fall);

endmodule

// File: rtl/pwr_mode_fsm.sv
`timescale 1ns/1ps
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int N_PERIPH    = 8,
  parameter int ACK_TIMEOUT = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_code,
  input  logic [N_PERIPH-1:0] run_en,
  input  logic [N_PERIPH-1:0] sleep_en,
  input  logic [N_PERIPH-1:0] irq,
  input  logic [N_PERIPH-1:0] stop_ack,
  input  logic                wdt_event,
  input  logic                nmi_fall,
  input  logic                ext_wake_seen,
  output pwr_state_e          state,
  output logic [N_PERIPH-1:0] stop_mask
);
  localparam int CNT_W = (ACK_TIMEOUT > 1) ? $clog2(ACK_TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_TIMEOUT - 1);

  pwr_state_e          state_q, state_d;
  logic [N_PERIPH-1:0] mask_q, mask_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                deep_tgt_q, deep_tgt_d;
  logic                pend_q, pend_d;

  logic all_acked, sleep_irq, idle_wake, sleep_wake;

  assign all_acked  = &(stop_ack | ~mask_q);
  assign sleep_irq  = |(irq & run_en & sleep_en);
  assign idle_wake  = wdt_event | nmi_fall | (|irq);
  assign sleep_wake = wdt_event | nmi_fall | sleep_irq | pend_q;

  always_comb begin
    state_d    = state_q;
    mask_d     = mask_q;
    cnt_d      = cnt_q;
    deep_tgt_d = deep_tgt_q;
    pend_d     = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        mask_d = '0;
        if (req_valid) begin
          unique case (req_code)
            MODE_IDLE: state_d = ST_IDLE;
            MODE_SLEEP: begin
              state_d    = ST_STOP_REQ;
              mask_d     = run_en & ~sleep_en;
              deep_tgt_d = 1'b0;
              cnt_d      = '0;
            end
            MODE_DEEP: begin
              state_d    = ST_STOP_REQ;
              mask_d     = run_en;
              deep_tgt_d = 1'b1;
              cnt_d      = '0;
            end
            default: state_d = ST_RUN;
          endcase
        end
      end
      ST_IDLE: begin
        if (idle_wake) state_d = ST_RUN;
      end
      ST_STOP_REQ: begin
        pend_d = pend_q | (!deep_tgt_q & (wdt_event | nmi_fall));
        cnt_d  = cnt_q + 1'b1;
        if (all_acked || (cnt_q == CNT_LAST)) state_d = ST_GATE_PER;
      end
      ST_GATE_PER: begin
        pend_d  = pend_q | (!deep_tgt_q & (wdt_event | nmi_fall));
        state_d = ST_GATE_CPU;
      end
      ST_GATE_CPU: begin
        pend_d  = pend_q | (!deep_tgt_q & (wdt_event | nmi_fall));
        state_d = deep_tgt_q ? ST_DEEP : ST_SLEEP;
      end
      ST_SLEEP: begin
        if (sleep_wake) begin
          state_d = ST_RUN;
          mask_d  = '0;
        end else begin
          pend_d = pend_q;
        end
      end
      ST_DEEP: begin
        if (ext_wake_seen) begin
          state_d = ST_RUN;
          mask_d  = '0;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      mask_q     <= '0;
      cnt_q      <= '0;
      deep_tgt_q <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      mask_q     <= mask_d;
      cnt_q      <= cnt_d;
      deep_tgt_q <= deep_tgt_d;
      pend_q     <= pend_d;
    end
  end

  assign state     = state_q;
  assign stop_mask = mask_q;

  // R7
  deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEEP && !ext_wake_seen) |=> state_q == ST_DEEP);

  // R9
  ack_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP_REQ && cnt_q == CNT_LAST) |=> state_q == ST_GATE_PER);

  // R10
  seq_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GATE_PER) |=> (state_q == ST_GATE_CPU && $stable(mask_q)));

  // R8
  stop_mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP_REQ) |=> $stable(mask_q));

endmodule

// File: rtl/pwr_clk_decode.sv
`timescale 1ns/1ps
module pwr_clk_decode
  import pwr_mode_pkg::*;
#(
  parameter int N_PERIPH = 8
) (
  input  pwr_state_e          state,
  input  logic [N_PERIPH-1:0] stop_mask,
  input  logic [N_PERIPH-1:0] run_en,
  input  logic [N_PERIPH-1:0] sleep_en,
  output logic                cpu_clk_en,
  output logic                sys_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic [N_PERIPH-1:0] stop_req,
  output logic [1:0]          mode_code
);
  always_comb begin
    cpu_clk_en    = 1'b1;
    sys_clk_en    = 1'b1;
    periph_clk_en = run_en;
    stop_req      = '0;
    mode_code     = MODE_RUN;
    unique case (state)
      ST_RUN: ;
      ST_IDLE: begin
        cpu_clk_en = 1'b0;
        mode_code  = MODE_IDLE;
      end
      ST_STOP_REQ: stop_req = stop_mask;
      ST_GATE_PER: begin
        stop_req      = stop_mask;
        periph_clk_en = run_en & ~stop_mask;
      end
      ST_GATE_CPU: begin
        stop_req      = stop_mask;
        periph_clk_en = run_en & ~stop_mask;
        cpu_clk_en    = 1'b0;
      end
      ST_SLEEP: begin
        stop_req      = stop_mask;
        periph_clk_en = run_en & sleep_en;
        cpu_clk_en    = 1'b0;
        mode_code     = MODE_SLEEP;
      end
      ST_DEEP: begin
        stop_req      = stop_mask;
        periph_clk_en = '0;
        cpu_clk_en    = 1'b0;
        sys_clk_en    = 1'b0;
        mode_code     = MODE_DEEP;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int N_PERIPH    = 8,
  parameter int ACK_TIMEOUT = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_req_valid,
  input  logic [1:0]          mode_req_code,
  input  logic [N_PERIPH-1:0] periph_run_en,
  input  logic [N_PERIPH-1:0] periph_sleep_en,
  input  logic [N_PERIPH-1:0] periph_irq,
  input  logic                wdt_event,
  input  logic                nmi_n,
  input  logic                ext_wake,
  input  logic [N_PERIPH-1:0] periph_stop_ack,
  output logic [N_PERIPH-1:0] periph_stop_req,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                cpu_clk_en,
  output logic                sys_clk_en,
  output logic [1:0]          mode_status
);
  logic                rst_sync_n;
  logic                nmi_fall, ext_wake_seen, deep_active;
  pwr_state_e          state;
  logic [N_PERIPH-1:0] stop_mask;

  assign deep_active = (state == ST_DEEP);

  pwr_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_sync_n)
  );

  pwr_wake_detect #(.SYNC_STAGES(SYNC_STAGES)) i_wake_detect (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .nmi_n         (nmi_n),
    .ext_wake      (ext_wake),
    .deep_active   (deep_active),
    .nmi_fall      (nmi_fall),
    .ext_wake_seen (ext_wake_seen)
  );

  pwr_mode_fsm #(.N_PERIPH(N_PERIPH), .ACK_TIMEOUT(ACK_TIMEOUT)) i_mode_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .req_valid     (mode_req_valid),
    .req_code      (mode_req_code),
    .run_en        (periph_run_en),
    .sleep_en      (periph_sleep_en),
    .irq           (periph_irq),
    .stop_ack      (periph_stop_ack),
    .wdt_event     (wdt_event),
    .nmi_fall      (nmi_fall),
    .ext_wake_seen (ext_wake_seen),
    .state         (state),
    .stop_mask     (stop_mask)
  );

  pwr_clk_decode #(.N_PERIPH(N_PERIPH)) i_clk_decode (
    .state         (state),
    .stop_mask     (stop_mask),
    .run_en        (periph_run_en),
    .sleep_en      (periph_sleep_en),
    .cpu_clk_en    (cpu_clk_en),
    .sys_clk_en    (sys_clk_en),
    .periph_clk_en (periph_clk_en),
    .stop_req      (periph_stop_req),
    .mode_code     (mode_status)
  );

  // R8
  periph_before_cpu_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($fell(cpu_clk_en) && mode_status != MODE_IDLE) |-> (periph_clk_en & periph_stop_req) == '0);

  // R8
  sys_after_cpu_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(sys_clk_en) |-> !$past(cpu_clk_en));

  // R7
  deep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sys_clk_en |-> (!cpu_clk_en && periph_clk_en == '0 && mode_status == MODE_DEEP));

endmodule

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         mode_req_valid;
  logic [1:0]   mode_req_code;
  logic [N-1:0] periph_run_en, periph_sleep_en, periph_irq, periph_stop_ack;
  logic         wdt_event, nmi_n, ext_wake;
  logic [N-1:0] periph_stop_req, periph_clk_en;
  logic         cpu_clk_en, sys_clk_en;
  logic [1:0]   mode_status;

  int errors = 0;
  int checks = 0;
  int ack_dly [N];
  int ack_cnt [N];

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.N_PERIPH(N)) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_req_valid(mode_req_valid), .mode_req_code(mode_req_code),
    .periph_run_en(periph_run_en), .periph_sleep_en(periph_sleep_en), .periph_irq(periph_irq),
    .wdt_event(wdt_event), .nmi_n(nmi_n), .ext_wake(ext_wake), .periph_stop_ack(periph_stop_ack),
    .periph_stop_req(periph_stop_req), .periph_clk_en(periph_clk_en), .cpu_clk_en(cpu_clk_en),
    .sys_clk_en(sys_clk_en), .mode_status(mode_status)
  );

  // peripheral model: acknowledge a stop request after a per-peripheral delay
  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!periph_stop_req[i]) ack_cnt[i] = 0;
      else if (ack_cnt[i] < 1000) ack_cnt[i] = ack_cnt[i] + 1;
      periph_stop_ack[i] = periph_stop_req[i] && (ack_cnt[i] > ack_dly[i]);
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_periph(input logic [1:0] m, input logic [N-1:0] run, input logic [N-1:0] slp);
    case (m)
      2'd2:    return run & slp;
      2'd3:    return '0;
      default: return run;
    endcase
  endfunction

  task automatic check_mode(input string req, input logic [1:0] m);
    chk(req, "mode_status", 32'(mode_status), 32'(m));
    chk(req, "cpu_clk_en", 32'(cpu_clk_en), 32'(m == 2'd0));
    chk(req, "sys_clk_en", 32'(sys_clk_en), 32'(m != 2'd3));
    chk(req, "periph_clk_en", 32'(periph_clk_en), 32'(exp_periph(m, periph_run_en, periph_sleep_en)));
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic write_mode(input logic [1:0] m);
    @(negedge clk);
    mode_req_valid = 1'b1;
    mode_req_code  = m;
    @(negedge clk);
    mode_req_valid = 1'b0;
  endtask

  task automatic pulse_wdt();
    wdt_event = 1'b1;
    @(negedge clk);
    wdt_event = 1'b0;
  endtask

  task automatic set_delays(input int d);
    for (int i = 0; i < N; i++) ack_dly[i] = d;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(3);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] run, slp, irqv;
    logic [1:0]   m;
    int           src;
    logic         woken;
    string        tag;

    void'($urandom(32'd20240611));
    rst_n = 1'b0; mode_req_valid = 1'b0; mode_req_code = 2'd0;
    periph_run_en = 8'hA5; periph_sleep_en = 8'h0F; periph_irq = '0;
    wdt_event = 1'b0; nmi_n = 1'b1; ext_wake = 1'b0; periph_stop_ack = '0;
    set_delays(0);
    for (int i = 0; i < N; i++) ack_cnt[i] = 0;
    cycles(3);
    rst_n = 1'b1;
    cycles(3);

    // R1 reset state
    check_mode("R1", 2'd0);
    chk("R1", "stop_req", 32'(periph_stop_req), 32'd0);
    // R2 run tracks enables
    periph_run_en = 8'h3C;
    #0.5;
    chk("R2", "periph_clk_en", 32'(periph_clk_en), 32'h3C);

    // R3 idle entry, R4 wake by watchdog
    write_mode(2'd1);
    check_mode("R3", 2'd1);
    ext_wake = 1'b1; cycles(1); ext_wake = 1'b0; cycles(4);
    check_mode("R4", 2'd1);
    pulse_wdt();
    check_mode("R4", 2'd0);

    // R4 NMI fall latency
    cycles(2);
    write_mode(2'd1);
    nmi_n = 1'b0;
    cycles(2);
    chk("R4", "nmi early", 32'(mode_status), 32'd1);
    cycles(1);
    chk("R4", "nmi wake", 32'(mode_status), 32'd0);
    nmi_n = 1'b1; cycles(5);

    // R4 interrupt wake
    write_mode(2'd1);
    periph_irq = 8'h08;
    cycles(1);
    chk("R4", "irq wake", 32'(mode_status), 32'd0);
    periph_irq = '0; cycles(2);

    // R8 ordered sleep entry with prompt acks
    periph_run_en = 8'hFF; periph_sleep_en = 8'h0F; set_delays(0);
    write_mode(2'd2);
    chk("R8", "stop_req", 32'(periph_stop_req), 32'hF0);
    chk("R8", "periph pre", 32'(periph_clk_en), 32'hFF);
    cycles(1);
    chk("R8", "periph gated", 32'(periph_clk_en), 32'h0F);
    chk("R8", "cpu still on", 32'(cpu_clk_en), 32'd1);
    cycles(1);
    chk("R8", "cpu gated", 32'(cpu_clk_en), 32'd0);
    chk("R8", "status pending", 32'(mode_status), 32'd0);
    cycles(1);
    check_mode("R5", 2'd2);
    // R6 gated irq ignored, clocked irq wakes
    periph_irq = 8'h80; cycles(3);
    chk("R6", "gated irq", 32'(mode_status), 32'd2);
    periph_irq = 8'h81; cycles(1);
    chk("R6", "clocked irq", 32'(mode_status), 32'd0);
    chk("R8", "stop released", 32'(periph_stop_req), 32'd0);
    periph_irq = '0; cycles(2);

    // R9 timeout, R10 ignored request, R11 remembered watchdog
    periph_sleep_en = 8'hF0; set_delays(0); ack_dly[2] = 100000;
    write_mode(2'd2);
    cycles(2);
    pulse_wdt();
    mode_req_valid = 1'b1; mode_req_code = 2'd1;
    cycles(1);
    mode_req_valid = 1'b0;
    cycles(11);
    chk("R9", "before timeout", 32'(periph_clk_en), 32'hFF);
    cycles(1);
    chk("R9", "after timeout", 32'(periph_clk_en), 32'hF0);
    cycles(2);
    chk("R10", "sleep reached", 32'(mode_status), 32'd2);
    cycles(1);
    chk("R11", "pending wake", 32'(mode_status), 32'd0);
    set_delays(0); cycles(2);

    // R7 deep sleep
    periph_run_en = 8'h5A;
    write_mode(2'd3);
    cycles(3);
    check_mode("R7", 2'd3);
    chk("R7", "stop_req", 32'(periph_stop_req), 32'h5A);
    pulse_wdt(); nmi_n = 1'b0; periph_irq = 8'hFF; cycles(6);
    chk("R7", "ignored", 32'(mode_status), 32'd3);
    nmi_n = 1'b1; periph_irq = '0; cycles(4);
    #1 ext_wake = 1'b1; #1 ext_wake = 1'b0;
    cycles(3);
    check_mode("R7", 2'd0);
    cycles(4);

    // R12 reset priority from deep sleep
    write_mode(2'd3);
    cycles(3);
    chk("R12", "in deep", 32'(mode_status), 32'd3);
    #1 rst_n = 1'b0;
    #0.5;
    check_mode("R12", 2'd0);
    cycles(2); rst_n = 1'b1; cycles(3);

    // random mix
    for (int it = 0; it < 40; it++) begin
      run = N'($urandom); slp = N'($urandom);
      m = 2'(1 + $urandom % 3);
      for (int i = 0; i < N; i++) ack_dly[i] = int'($urandom % 21);
      periph_run_en = run; periph_sleep_en = slp;
      write_mode(m);
      for (int w = 0; w < 40 && mode_status != m; w++) @(negedge clk);
      tag = (m == 2'd1) ? "R3" : (m == 2'd2) ? "R5" : "R7";
      check_mode(tag, m);
      src  = int'($urandom % 5);
      irqv = N'($urandom);
      case (m)
        2'd1:    woken = (src < 2) || (src == 2 && irqv != 0) || (src == 4 && (irqv & ~(run & slp)) != 0);
        2'd2:    woken = (src < 2) || (src == 2 && (irqv & run & slp) != 0);
        default: woken = (src == 3);
      endcase
      case (src)
        0: pulse_wdt();
        1: nmi_n = 1'b0;
        2: periph_irq = irqv;
        3: begin ext_wake = 1'b1; @(negedge clk); ext_wake = 1'b0; end
        default: periph_irq = irqv & ~(run & slp);
      endcase
      cycles(5);
      tag = (m == 2'd1) ? "R4" : (m == 2'd2) ? "R6" : "R7";
      chk(tag, "wake decision", 32'(mode_status), woken ? 32'd0 : 32'(m));
      periph_irq = '0; nmi_n = 1'b1;
      if (!woken) begin
        if (m == 2'd3) begin ext_wake = 1'b1; @(negedge clk); ext_wake = 1'b0; end
        else pulse_wdt();
      end
      cycles(6);
      check_mode("R2", 2'd0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule